// File: doc/BRIEF.md
# Random-Source Status, Interrupt and Entropy Register Block

This block is the register-facing side of a true random number collector. Software reaches it through a plain 32-bit read/write register port; the entropy engine behind it delivers one full entropy sample (several 32-bit words at once) over a valid/ready input. It also raises individual error events. The block keeps a five-bit event status with its own mask and write-one-to-clear register. It rolls every unmasked event into one bit of a host-level pending register, and drives a single interrupt line from that host bit and a host mask.

The entropy words are held in read-only registers that return to zero as they are read, so a word can be consumed only once. A software reset sequence clears the collection state and raises a not-idle indicator for a fixed number of cycles. While that sequence runs, and while the random-source clock enable is off, writes to the sample-count register are dropped, so software writes it again until it reads back. A down-counting watchdog starts when the source is switched on and flags an event if no sample arrives in time.

Back-pressure rules for the entropy input: `ent_ready` is high only while the source is enabled, no reset sequence is running and status bit 0 is clear. A sample is taken on a clock edge where `ent_valid` and `ent_ready` are both high. After that, `ent_ready` stays low until software clears status bit 0. The engine must hold `ent_data` stable while `ent_valid` is high. The register port has no back-pressure: every access is taken in the cycle it is presented.

Top module: `trng_regfile`

## Requirements
- R1: After reset the event mask (0x100) reads 0x1F, the event status (0x104) reads 0, the host mask (0xA04) reads 0x400, the idle word (0xF10) reads 1, and `irq`, `src_en` and `ent_ready` are 0.
- R2: Configuration registers read back what was written, limited to their widths: oscillator select 0x10C (2 bits), debug control 0x138 (4 bits), DMA enable 0x1C8 (1 bit), watchdog value 0x1D8 (32 bits), power-down 0xA78 (1 bit), event mask 0x100 (5 bits), and host mask 0xA04, where only bit 10 is kept.
- R3: Event status bits are set regardless of the mask: bit 0 when a sample is accepted, bit 1 by `ev_autocorr`, bit 2 by `ev_crngt`, bit 3 by `ev_vn`, bit 4 by watchdog expiry. Bit 0 is set on the edge of acceptance.
- R4: Writing 0x108 clears exactly the status bits written as 1; writing 0xFFFFFFFF clears all of them.
- R5: `ent_ready` equals source enabled AND not resetting AND status bit 0 clear. An accepted sample places word k, taken from `ent_data[32k+31:32k]`, at address 0x114+4k.
- R6: Reading an entropy word returns its value and clears it, so the next read of the same word returns 0.
- R7: Host pending bit 10 (0xA00) is set on the edge after any status bit whose mask bit is 0 is set. A write of bit 10 to 0xA08 clears it when no unmasked status remains. `irq` is host pending AND NOT host mask bit 10, so it rises one cycle after the status bit.
- R8: A 0-to-1 write of 0x12C loads the watchdog with the value at 0x1D8 (V). Without a sample, status bit 4 is set on the (V+1)-th edge after the write edge. Accepting a sample, or disabling the source, stops the watchdog.
- R9: Writing 1 to 0x140 starts a reset sequence of RST_CYCLES cycles. It clears the status, the entropy words, the source enable, the clock enable (0x1C4) and the sample count (0x130). The idle word 0xF10 reads 0 while the sequence runs.
- R10: A write to the sample count (0x130) takes effect only while the clock enable (0x1C4 bit 0) is 1 and no reset sequence is running; otherwise it is dropped.
- R11: A read returns its data on `bus_rdata` with `bus_rvalid` high in the cycle after the access.
- R12: `pwr_down` follows bit 0 of register 0xA78.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| bus_rdata | output | 32 | Read data |
| ent_valid | input | 1 | Entropy sample offered |
| ent_ready | output | 1 | Entropy sample can be taken |
| ent_data | input | WORDS*32 | Entropy sample, word 0 in the low bits |
| ev_autocorr | input | 1 | Autocorrelation failure event |
| ev_crngt | input | 1 | Continuous test failure event |
| ev_vn | input | 1 | Von Neumann corrector event |
| src_en | output | 1 | Random source enable |
| rng_clk_en | output | 1 | Random source clock enable |
| osc_sel | output | OSC_W | Selected ring oscillator |
| sample_cnt | output | 32 | Sampling interval setting |
| pwr_down | output | 1 | Power-down request |
| irq | output | 1 | Interrupt request |

## Verification
A read result is due one cycle after the access edge, so the bench samples `bus_rdata` at the falling edge that follows. Status bits, entropy words and register contents change on the write or acceptance edge itself and are checked from the next falling edge. `irq` is expected low at the falling edge right after a status bit sets and high one falling edge later. Host-mask changes act on `irq` at once. The watchdog check counts edges from the enabling write edge and expects status bit 4 after V+1 edges and `irq` one edge later.

// File: rtl/trng_pkg.sv
package trng_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned NEV = 5;

  localparam logic [AW-1:0] A_EVT_MASK  = 12'h100;
  localparam logic [AW-1:0] A_EVT_STAT  = 12'h104;
  localparam logic [AW-1:0] A_EVT_CLR   = 12'h108;
  localparam logic [AW-1:0] A_OSC_SEL   = 12'h10C;
  localparam logic [AW-1:0] A_ENT_BASE  = 12'h114;
  localparam logic [AW-1:0] A_SRC_EN    = 12'h12C;
  localparam logic [AW-1:0] A_SMPL      = 12'h130;
  localparam logic [AW-1:0] A_DBG       = 12'h138;
  localparam logic [AW-1:0] A_SRST      = 12'h140;
  localparam logic [AW-1:0] A_CLK_EN    = 12'h1C4;
  localparam logic [AW-1:0] A_DMA_EN    = 12'h1C8;
  localparam logic [AW-1:0] A_WDOG      = 12'h1D8;
  localparam logic [AW-1:0] A_HOST_PEND = 12'hA00;
  localparam logic [AW-1:0] A_HOST_MASK = 12'hA04;
  localparam logic [AW-1:0] A_HOST_CLR  = 12'hA08;
  localparam logic [AW-1:0] A_PWR_DN    = 12'hA78;
  localparam logic [AW-1:0] A_IDLE      = 12'hF10;

  // event status bit positions
  localparam int unsigned EV_SAMPLE = 0;
  localparam int unsigned EV_ACORR  = 1;
  localparam int unsigned EV_CRNGT  = 2;
  localparam int unsigned EV_VN     = 3;
  localparam int unsigned EV_WDOG   = 4;

  localparam int unsigned HOST_BIT = 10;
endpackage

// File: rtl/trng_evt_ctrl.sv
module trng_evt_ctrl
  import trng_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           flush,
  input  logic [NEV-1:0] ev_set,
  input  logic           mask_we,
  input  logic [NEV-1:0] mask_val,
  input  logic           clr_we,
  input  logic [NEV-1:0] clr_val,
  input  logic           hmask_we,
  input  logic           hmask_val,
  input  logic           hclr_we,
  input  logic           hclr_val,
  output logic [NEV-1:0] mask_q,
  output logic [NEV-1:0] stat_q,
  output logic           hpend_q,
  output logic           hmask_q,
  output logic           irq
);
  logic [NEV-1:0] clr_bits;
  logic           any_unmasked;

  assign clr_bits     = clr_we ? clr_val : '0;
  assign any_unmasked = |(stat_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_we) begin
      mask_q <= mask_val;
    end
  end

  // new events win over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (flush) begin
      stat_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr_bits) | ev_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hmask_q <= 1'b1;
      hpend_q <= 1'b0;
    end else begin
      if (hmask_we) hmask_q <= hmask_val;
      hpend_q <= any_unmasked | (hpend_q & ~(hclr_we & hclr_val));
    end
  end

  assign irq = hpend_q & ~hmask_q;
endmodule

// File: rtl/trng_ent_store.sv
module trng_ent_store #(
  parameter int unsigned WORDS = 6,
  localparam int unsigned IDXW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  cap,
  input  logic [WORDS*32-1:0]   cap_data,
  input  logic                  rd_en,
  input  logic [IDXW-1:0]       rd_idx,
  output logic [31:0]           rd_word
);
  logic [31:0] word_q [WORDS];

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[k] <= '0;
      end else if (flush) begin
        word_q[k] <= '0;
      end else if (cap) begin
        word_q[k] <= cap_data[32*k +: 32];
      end else if (rd_en && rd_idx == IDXW'(k)) begin
        word_q[k] <= '0;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (rd_idx == IDXW'(k)) rd_word = word_q[k];
    end
  end
endmodule

// File: rtl/trng_wdog.sv
module trng_wdog #(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic          armed_q;

  assign expire = armed_q & run & (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cnt_q   <= load_val;
      armed_q <= 1'b1;
    end else if (!run || expire) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/trng_regfile.sv
module trng_regfile
  import trng_pkg::*;
#(
  parameter int unsigned WORDS      = 6,
  parameter int unsigned RST_CYCLES = 4,
  parameter int unsigned OSC_W      = 2,
  parameter int unsigned DBG_W      = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 bus_rvalid,
  output logic [31:0]          bus_rdata,
  input  logic                 ent_valid,
  output logic                 ent_ready,
  input  logic [WORDS*32-1:0]  ent_data,
  input  logic                 ev_autocorr,
  input  logic                 ev_crngt,
  input  logic                 ev_vn,
  output logic                 src_en,
  output logic                 rng_clk_en,
  output logic [OSC_W-1:0]     osc_sel,
  output logic [31:0]          sample_cnt,
  output logic                 pwr_down,
  output logic                 irq
);
  localparam int unsigned IDXW = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned RCW  = $clog2(RST_CYCLES + 1);
  localparam logic [AW-1:0] ENT_LAST = A_ENT_BASE + AW'(4 * (WORDS - 1));

  logic wr, rd;
  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;

  // ---------------- reset sequence ----------------
  logic [RCW-1:0] rst_cnt_q;
  logic           busy, srst_go;
  assign srst_go = wr && bus_addr == A_SRST && bus_wdata[0];
  assign busy    = rst_cnt_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rst_cnt_q <= '0;
    else if (srst_go) rst_cnt_q <= RCW'(RST_CYCLES);
    else if (busy)    rst_cnt_q <= rst_cnt_q - 1'b1;
  end

  // ---------------- configuration registers ----------------
  logic [DBG_W-1:0] dbg_q;
  logic             dma_q;
  logic [31:0]      wdog_val_q;
  logic             src_rise;
  assign src_rise = wr && bus_addr == A_SRC_EN && bus_wdata[0] && !src_en && !busy && !srst_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_en     <= 1'b0;
      rng_clk_en <= 1'b0;
      sample_cnt <= '0;
      osc_sel    <= '0;
      dbg_q      <= '0;
      dma_q      <= 1'b0;
      wdog_val_q <= '0;
      pwr_down   <= 1'b0;
    end else if (srst_go) begin
      src_en     <= 1'b0;
      rng_clk_en <= 1'b0;
      sample_cnt <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_SRC_EN:  if (!busy) src_en <= bus_wdata[0];
        A_CLK_EN:  rng_clk_en <= bus_wdata[0];
        A_SMPL:    if (rng_clk_en && !busy) sample_cnt <= bus_wdata;
        A_OSC_SEL: osc_sel <= bus_wdata[OSC_W-1:0];
        A_DBG:     dbg_q <= bus_wdata[DBG_W-1:0];
        A_DMA_EN:  dma_q <= bus_wdata[0];
        A_WDOG:    wdog_val_q <= bus_wdata;
        A_PWR_DN:  pwr_down <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  // ---------------- events and interrupts ----------------
  logic [NEV-1:0] mask_q, stat_q, ev_set;
  logic           hpend_q, hmask_q, accept, wd_expire;

  assign ent_ready = src_en & ~busy & ~stat_q[EV_SAMPLE];
  assign accept    = ent_valid & ent_ready;

  always_comb begin
    ev_set = '0;
    ev_set[EV_SAMPLE] = accept;
    ev_set[EV_ACORR]  = ev_autocorr;
    ev_set[EV_CRNGT]  = ev_crngt;
    ev_set[EV_VN]     = ev_vn;
    ev_set[EV_WDOG]   = wd_expire;
    if (busy) ev_set = '0;
  end

  trng_evt_ctrl u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (srst_go),
    .ev_set    (ev_set),
    .mask_we   (wr && bus_addr == A_EVT_MASK),
    .mask_val  (bus_wdata[NEV-1:0]),
    .clr_we    (wr && bus_addr == A_EVT_CLR),
    .clr_val   (bus_wdata[NEV-1:0]),
    .hmask_we  (wr && bus_addr == A_HOST_MASK),
    .hmask_val (bus_wdata[HOST_BIT]),
    .hclr_we   (wr && bus_addr == A_HOST_CLR),
    .hclr_val  (bus_wdata[HOST_BIT]),
    .mask_q    (mask_q),
    .stat_q    (stat_q),
    .hpend_q   (hpend_q),
    .hmask_q   (hmask_q),
    .irq       (irq)
  );

  trng_wdog #(.CW(32)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (src_rise),
    .load_val (wdog_val_q),
    .run      (src_en & ~busy & ~stat_q[EV_SAMPLE]),
    .expire   (wd_expire)
  );

  // ---------------- entropy words ----------------
  logic            ent_hit;
  logic [AW-1:0]   ent_off;
  logic [IDXW-1:0] ent_idx;
  logic [31:0]     ent_word;

  assign ent_off = bus_addr - A_ENT_BASE;
  assign ent_idx = ent_off[IDXW+1:2];
  assign ent_hit = bus_addr >= A_ENT_BASE && bus_addr <= ENT_LAST && bus_addr[1:0] == 2'b00;

  trng_ent_store #(.WORDS(WORDS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (srst_go),
    .cap      (accept),
    .cap_data (ent_data),
    .rd_en    (rd && ent_hit),
    .rd_idx   (ent_idx),
    .rd_word  (ent_word)
  );

  // ---------------- read path ----------------
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_EVT_MASK:  rd_mux = 32'(mask_q);
      A_EVT_STAT:  rd_mux = 32'(stat_q);
      A_OSC_SEL:   rd_mux = 32'(osc_sel);
      A_SRC_EN:    rd_mux = 32'(src_en);
      A_SMPL:      rd_mux = sample_cnt;
      A_DBG:       rd_mux = 32'(dbg_q);
      A_CLK_EN:    rd_mux = 32'(rng_clk_en);
      A_DMA_EN:    rd_mux = 32'(dma_q);
      A_WDOG:      rd_mux = wdog_val_q;
      A_HOST_PEND: rd_mux = 32'(hpend_q) << HOST_BIT;
      A_HOST_MASK: rd_mux = 32'(hmask_q) << HOST_BIT;
      A_PWR_DN:    rd_mux = 32'(pwr_down);
      A_IDLE:      rd_mux = 32'(!busy);
      default:     rd_mux = ent_hit ? ent_word : '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/trng_regfile_chk.sv
module trng_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic       bus_we,
  input logic       bus_rvalid,
  input logic       ent_valid,
  input logic       ent_ready,
  input logic       src_en,
  input logic       irq,
  input logic [4:0] stat_q,
  input logic [4:0] mask_q,
  input logic       hpend_q
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> bus_rvalid); // R11
  AST_READY_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    ent_ready |-> src_en); // R5
  AST_SAMPLE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[0] |-> !ent_ready); // R5
  AST_ACCEPT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_ready) |=> stat_q[0]); // R3
  AST_HOST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & ~mask_q)) |=> hpend_q); // R7
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !hpend_q |-> !irq); // R7
endmodule

bind trng_regfile trng_regfile_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_we     (bus_we),
  .bus_rvalid (bus_rvalid),
  .ent_valid  (ent_valid),
  .ent_ready  (ent_ready),
  .src_en     (src_en),
  .irq        (irq),
  .stat_q     (stat_q),
  .mask_q     (mask_q),
  .hpend_q    (hpend_q)
);

// File: tb/sim_trng_regfile.sv
`timescale 1ns/1ps
module sim_trng_regfile;
  localparam int WORDS = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic ent_valid = 0, ent_ready;
  logic [WORDS*32-1:0] ent_data = '0;
  logic ev_autocorr = 0, ev_crngt = 0, ev_vn = 0;
  logic src_en, rng_clk_en, pwr_down, irq;
  logic [1:0] osc_sel;
  logic [31:0] sample_cnt;

  int n_chk = 0, n_err = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  trng_regfile u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk); bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    @(posedge clk);
    @(negedge clk); bus_en = 0;
    d = bus_rdata;
    if (bus_rvalid !== 1'b1) begin
      n_chk++; n_err++;
      $display("FAIL R11 actual rvalid=%b expected=1", bus_rvalid);
    end
  endtask

  // {is_write, addr, wdata, expected read}
  localparam int NV = 19;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h100, 32'h0,        32'h0},
    {1'b0, 12'h100, 32'h0,        32'h0},
    {1'b1, 12'h100, 32'hFFFFFFFF, 32'h0},
    {1'b0, 12'h100, 32'h0,        32'h1F},
    {1'b1, 12'h10C, 32'h7,        32'h0},
    {1'b0, 12'h10C, 32'h0,        32'h3},
    {1'b1, 12'h138, 32'hFFFFFFFA, 32'h0},
    {1'b0, 12'h138, 32'h0,        32'hA},
    {1'b1, 12'h1C8, 32'h1,        32'h0},
    {1'b0, 12'h1C8, 32'h0,        32'h1},
    {1'b1, 12'h1D8, 32'h1234,     32'h0},
    {1'b0, 12'h1D8, 32'h0,        32'h1234},
    {1'b1, 12'hA78, 32'h1,        32'h0},
    {1'b0, 12'hA78, 32'h0,        32'h1},
    {1'b1, 12'hA04, 32'hFFFFFFFF, 32'h0},
    {1'b0, 12'hA04, 32'h0,        32'h400},
    {1'b1, 12'hA04, 32'h0,        32'h0},
    {1'b0, 12'hA04, 32'h0,        32'h0},
    {1'b0, 12'h128, 32'h0,        32'h0}
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 src_en", 32'(src_en), 0);
    check("R1 ent_ready", 32'(ent_ready), 0);
    rd(12'h100, rv); check("R1 mask", rv, 32'h1F);
    rd(12'h104, rv); check("R1 status", rv, 0);
    rd(12'hA04, rv); check("R1 host mask", rv, 32'h400);
    rd(12'hF10, rv); check("R1 idle", rv, 1);

    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], rv);
        check($sformatf("R2 vec%0d", i), rv, VEC[i][31:0]);
      end
    end
    check("R12 pwr_down on", 32'(pwr_down), 1);
    wr(12'hA78, 0);
    check("R12 pwr_down off", 32'(pwr_down), 0);

    // R10 / R9 sample count and reset sequence
    wr(12'h1C4, 1);
    wr(12'h130, 50);
    rd(12'h130, rv); check("R10 accepted", rv, 50);
    check("R10 output", sample_cnt, 50);
    wr(12'h140, 1);
    rd(12'hF10, rv); check("R9 busy", rv, 0);
    rd(12'h130, rv); check("R9 sample cleared", rv, 0);
    rd(12'h1C4, rv); check("R9 clk_en cleared", rv, 0);
    wr(12'h140, 1);
    wr(12'h1C4, 1);
    wr(12'h130, 9);
    repeat (8) @(negedge clk);
    rd(12'h130, rv); check("R10 dropped while busy", rv, 0);
    rd(12'hF10, rv); check("R9 idle again", rv, 1);
    wr(12'h1C4, 0);
    wr(12'h130, 77);
    rd(12'h130, rv); check("R10 dropped clk off", rv, 0);
    wr(12'h1C4, 1);
    wr(12'h130, 77);
    rd(12'h130, rv); check("R10 retry", rv, 77);

    // R5 / R3 / R7 entropy capture
    wr(12'h100, 0);
    check("R5 ready off", 32'(ent_ready), 0);
    wr(12'h12C, 1);
    check("R5 ready on", 32'(ent_ready), 1);
    @(negedge clk);
    ent_valid = 1;
    for (int k = 0; k < WORDS; k++) ent_data[32*k +: 32] = 32'h1111_1111 * (k + 1) + 32'h0F;
    @(posedge clk);
    @(negedge clk); ent_valid = 0;
    check("R7 irq not yet", 32'(irq), 0);
    check("R5 ready drops", 32'(ent_ready), 0);
    @(negedge clk);
    check("R7 irq one later", 32'(irq), 1);
    rd(12'h104, rv); check("R3 sample bit", rv, 1);
    rd(12'hA00, rv); check("R7 host pend", rv, 32'h400);
    for (int k = 0; k < WORDS; k++) begin
      rd(12'(12'h114 + 4 * k), rv);
      check($sformatf("R5 word%0d", k), rv, 32'h1111_1111 * (k + 1) + 32'h0F);
    end
    rd(12'h114, rv); check("R6 cleared on read", rv, 0);
    rd(12'h128, rv); check("R6 last cleared", rv, 0);

    wr(12'hA04, 32'h400);
    check("R7 host masked", 32'(irq), 0);
    wr(12'hA04, 0);
    check("R7 host unmasked", 32'(irq), 1);
    wr(12'h108, 1);
    rd(12'h104, rv); check("R4 clear sample", rv, 0);
    check("R5 ready back", 32'(ent_ready), 1);
    wr(12'hA08, 32'h400);
    check("R7 host clear irq", 32'(irq), 0);
    rd(12'hA00, rv); check("R7 host clear pend", rv, 0);

    // R3 / R4 masked events
    wr(12'h100, 32'h1F);
    @(negedge clk); ev_vn = 1; ev_autocorr = 1;
    @(negedge clk); ev_vn = 0; ev_autocorr = 0;
    @(negedge clk);
    check("R7 masked no irq", 32'(irq), 0);
    rd(12'h104, rv); check("R3 masked events set", rv, 32'hA);
    rd(12'hA00, rv); check("R7 masked no pend", rv, 0);
    wr(12'h108, 2);
    rd(12'h104, rv); check("R4 single bit", rv, 8);
    wr(12'h108, 32'hFFFFFFFF);
    rd(12'h104, rv); check("R4 clear all", rv, 0);

    // R8 watchdog: V=5, status on edge E+6, irq after E+7
    wr(12'h12C, 0);
    wr(12'h1D8, 5);
    wr(12'h100, 32'h0F);
    wr(12'h12C, 1);
    repeat (6) @(negedge clk);
    check("R8 irq before expiry", 32'(irq), 0);
    @(negedge clk);
    check("R8 irq after expiry", 32'(irq), 1);
    rd(12'h104, rv); check("R8 watchdog bit", rv, 32'h10);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule